// File: doc/BRIEF.md
# Multi-Port Stream Packet Integrity Checker

This block sits behind several independent streaming sink ports, one per DMA channel, and judges every packet that arrives on each of them. A packet passes when it opens with a start marker, closes with an end marker after exactly the number of bytes software has programmed, and carries a payload in which every byte equals its own position in the packet modulo 256. Each port's verdicts feed two saturating counters, one for good packets and one for bad ones.

Software programs the expected packet length and reads or clears the counters through a small memory-mapped register port. That port has a fixed read latency of one cycle. The sinks never apply backpressure, so a traffic source can stream into all ports at full rate while the counters tally the results.

Top module: `stream_pkt_checker`

## Requirements
- R1: Every port's ready output is high at all times, including during reset release and while traffic flows.
- R2: A packet is good when four things hold. It begins with a beat carrying the start marker. It ends with a beat carrying the end marker. Its total count of valid bytes equals the programmed length. Byte i of the packet holds the value i modulo 256. Within a beat, bits [7:0] carry the earliest byte, and each following byte occupies the next 8 bits up. A good packet adds one to that port's good counter.
- R3: On a beat with the end marker, the empty field gives how many of the highest byte lanes are invalid. Those lanes are excluded from both the length count and the pattern check, whatever they contain. On beats without the end marker, the empty field is ignored and all byte lanes count.
- R4: A single valid byte that differs from its expected pattern value makes the packet bad and adds one to the bad counter instead of the good counter.
- R5: A packet whose valid byte count is below or above the programmed length is bad.
- R6: A start marker arriving while a packet is still open closes the open packet as bad and begins a new packet at that beat.
- R7: A beat arriving without a start marker while no packet is open opens a faulty packet. That packet is counted as exactly one bad packet when it is closed, either by an end marker or by a later start marker.
- R8: The ports are checked independently. Beats on several ports in the same cycle each update only their own port's counters.
- R9: The register map uses byte offsets. Offset 0x00 holds the expected length, which reads back as written and resets to 4096. Offset 0x10 + 8*p holds port p's good count. Offset 0x14 + 8*p holds port p's bad count. Any other offset reads as zero, and all counters reset to zero.
- R10: A write of any value to a counter's offset clears that counter and leaves every other counter unchanged.
- R11: A counter that has reached its maximum value stays there on further packets and does not wrap.
- R12: A register read returns its data with the valid flag exactly one cycle after the request. A counter shows a packet's verdict in a read request made two cycles after the clock edge that accepts that packet's end beat. A read made one cycle after that edge still shows the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_valid | input | NUM_PORTS | Per-port beat valid |
| st_ready | output | NUM_PORTS | Per-port ready, always high |
| st_sop | input | NUM_PORTS | Per-port start-of-packet marker |
| st_eop | input | NUM_PORTS | Per-port end-of-packet marker |
| st_empty | input | NUM_PORTS*log2(DATA_BYTES) | Per-port count of invalid top lanes on the end beat |
| st_data | input | NUM_PORTS*DATA_BYTES*8 | Per-port beat data, earliest byte in the low bits |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | REG_W | Register write data |
| reg_rd | input | 1 | Register read strobe |
| reg_rdata | output | REG_W | Register read data |
| reg_rvalid | output | 1 | Read data valid, one cycle after reg_rd |

## Verification
A verdict is registered on the edge that accepts an end beat. The counter moves on the following edge, and a read request placed on the edge after that returns the new value one cycle later. To stay clear of this pipeline, the bench idles two cycles after each packet before it reads back a counter. One directed case issues reads on consecutive cycles straight after an end beat to pin the exact edge where the count changes. All stimulus is applied and all outputs are sampled on the falling clock edge.

// File: rtl/pkchk_pkg.sv
package pkchk_pkg;

    // Register byte offsets; counter slots repeat per port at this stride.
    localparam int REG_LEN_OFS     = 'h00;
    localparam int REG_GOOD_BASE   = 'h10;
    localparam int REG_BAD_BASE    = 'h14;
    localparam int REG_PORT_STRIDE = 8;

    // Per-packet verdict produced by a lane, one cycle after the closing beat.
    typedef struct packed {
        logic good;   // packet closed by end marker and passed every check
        logic bad;    // packet closed by end marker and failed a check
        logic abort;  // open packet cut short by a new start marker
    } pkt_verdict_t;

    // Number of bad packets a verdict contributes (0..2).
    function automatic logic [1:0] bad_increment(input pkt_verdict_t v);
        return {1'b0, v.bad} + {1'b0, v.abort};
    endfunction

    function automatic logic [1:0] good_increment(input pkt_verdict_t v);
        return {1'b0, v.good};
    endfunction

endpackage

// File: rtl/pkchk_lane.sv
module pkchk_lane
    import pkchk_pkg::*;
#(
    parameter int DATA_BYTES = 64,
    parameter int LEN_W      = 16,
    localparam int EMPTY_W   = $clog2(DATA_BYTES),
    localparam int NV_W      = EMPTY_W + 1,
    localparam int SUM_W     = LEN_W + 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    beat_valid,
    input  logic                    beat_sop,
    input  logic                    beat_eop,
    input  logic [EMPTY_W-1:0]      beat_empty,
    input  logic [DATA_BYTES*8-1:0] beat_data,
    input  logic [LEN_W-1:0]        exp_len,
    output pkt_verdict_t            verdict
);

    logic               open_q;
    logic               fault_q;
    logic [LEN_W-1:0]   cnt_q;
    pkt_verdict_t       verdict_q;

    logic               starting;
    logic [LEN_W-1:0]   base;
    logic               base_fault;
    logic [NV_W-1:0]    nvalid;
    logic [SUM_W-1:0]   sum;
    logic [DATA_BYTES-1:0] miss;
    logic               fault_n;
    logic               pass_n;

    // Per byte lane: compare with the running position when the lane is in use.
    for (genvar j = 0; j < DATA_BYTES; j++) begin : g_byte
        assign miss[j] = (NV_W'(j) < nvalid) &&
                         (beat_data[8*j +: 8] != (base[7:0] + 8'(j)));
    end

    always_comb begin
        starting   = beat_sop || !open_q;
        base       = starting ? '0 : cnt_q;
        base_fault = starting ? !beat_sop : fault_q;
        nvalid     = beat_eop ? (NV_W'(DATA_BYTES) - NV_W'(beat_empty))
                              : NV_W'(DATA_BYTES);
        sum        = {1'b0, base} + SUM_W'(nvalid);
        fault_n    = base_fault || (|miss) || (sum > {1'b0, exp_len});
        pass_n     = !fault_n && (sum == {1'b0, exp_len});
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q    <= 1'b0;
            fault_q   <= 1'b0;
            cnt_q     <= '0;
            verdict_q <= '0;
        end else begin
            verdict_q <= '0;
            if (beat_valid) begin
                verdict_q.abort <= beat_sop && open_q;
                if (beat_eop) begin
                    open_q        <= 1'b0;
                    fault_q       <= 1'b0;
                    cnt_q         <= '0;
                    verdict_q.good <= pass_n;
                    verdict_q.bad  <= !pass_n;
                end else begin
                    open_q  <= 1'b1;
                    fault_q <= fault_n;
                    cnt_q   <= sum[LEN_W-1:0];
                end
            end
        end
    end

    assign verdict = verdict_q;

    AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (rst)
        !(verdict_q.good && verdict_q.bad));                                  // R2
    AST_GOOD_AFTER_EOP: assert property (@(posedge clk) disable iff (rst)
        verdict_q.good |-> $past(beat_valid && beat_eop));                    // R2
    AST_ABORT_AFTER_SOP: assert property (@(posedge clk) disable iff (rst)
        verdict_q.abort |-> $past(beat_valid && beat_sop));                   // R6
    AST_IDLE_NO_VERDICT: assert property (@(posedge clk) disable iff (rst)
        !beat_valid |=> (verdict_q == '0));                                   // R8

endmodule

// File: rtl/pkchk_sat_cnt.sv
module pkchk_sat_cnt #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic [1:0]       add,
    output logic [CNT_W-1:0] count
);

    localparam logic [CNT_W:0] MAX_EXT = {1'b0, {CNT_W{1'b1}}};

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W:0]   next_ext;

    always_comb begin
        next_ext = {1'b0, cnt_q} + (CNT_W+1)'(add);
        if (next_ext > MAX_EXT) next_ext = MAX_EXT;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) cnt_q <= '0;
        else            cnt_q <= next_ext[CNT_W-1:0];
    end

    assign count = cnt_q;

    AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
        (!$past(clr) && ($past(cnt_q) == {CNT_W{1'b1}})) |-> (cnt_q == {CNT_W{1'b1}})); // R11
    AST_NO_DECREASE: assert property (@(posedge clk) disable iff (rst)
        !$past(clr) |-> (cnt_q >= $past(cnt_q)));                             // R11
    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt_q == '0));                                               // R10

endmodule

// File: rtl/pkchk_regs.sv
module pkchk_regs
    import pkchk_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int CNT_W     = 32,
    parameter int LEN_W     = 16,
    parameter int ADDR_W    = 8,
    parameter int REG_W     = 32,
    parameter int RESET_LEN = 4096
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [ADDR_W-1:0]          reg_addr,
    input  logic                       reg_wr,
    input  logic [REG_W-1:0]           reg_wdata,
    input  logic                       reg_rd,
    output logic [REG_W-1:0]           reg_rdata,
    output logic                       reg_rvalid,
    input  logic [NUM_PORTS*CNT_W-1:0] good_cnt,
    input  logic [NUM_PORTS*CNT_W-1:0] bad_cnt,
    output logic [LEN_W-1:0]           exp_len,
    output logic [NUM_PORTS-1:0]       good_clr,
    output logic [NUM_PORTS-1:0]       bad_clr
);

    logic                 len_hit;
    logic [NUM_PORTS-1:0] good_hit;
    logic [NUM_PORTS-1:0] bad_hit;
    logic [LEN_W-1:0]     len_q;
    logic [REG_W-1:0]     rd_mux;
    logic [REG_W-1:0]     rdata_q;
    logic                 rvalid_q;

    assign len_hit = (reg_addr == ADDR_W'(REG_LEN_OFS));

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_dec
        assign good_hit[p] = (reg_addr == ADDR_W'(REG_GOOD_BASE + REG_PORT_STRIDE*p));
        assign bad_hit[p]  = (reg_addr == ADDR_W'(REG_BAD_BASE  + REG_PORT_STRIDE*p));
        assign good_clr[p] = reg_wr && good_hit[p];
        assign bad_clr[p]  = reg_wr && bad_hit[p];
    end

    always_comb begin
        rd_mux = '0;
        if (len_hit) rd_mux = REG_W'(len_q);
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (good_hit[p]) rd_mux = REG_W'(good_cnt[p*CNT_W +: CNT_W]);
            if (bad_hit[p])  rd_mux = REG_W'(bad_cnt[p*CNT_W +: CNT_W]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            len_q    <= LEN_W'(RESET_LEN);
            rdata_q  <= '0;
            rvalid_q <= 1'b0;
        end else begin
            if (reg_wr && len_hit) len_q <= reg_wdata[LEN_W-1:0];
            rvalid_q <= reg_rd;
            if (reg_rd) rdata_q <= rd_mux;
        end
    end

    assign exp_len    = len_q;
    assign reg_rdata  = rdata_q;
    assign reg_rvalid = rvalid_q;

    AST_RD_LATENCY: assert property (@(posedge clk) disable iff (rst)
        reg_rd |=> reg_rvalid);                                               // R12
    AST_NO_STRAY_RVALID: assert property (@(posedge clk) disable iff (rst)
        !reg_rd |=> !reg_rvalid);                                             // R12
    AST_LEN_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !(reg_wr && len_hit) |=> $stable(len_q));                             // R9

endmodule

// File: rtl/stream_pkt_checker.sv
module stream_pkt_checker
    import pkchk_pkg::*;
#(
    parameter int NUM_PORTS  = 4,
    parameter int DATA_BYTES = 64,
    parameter int LEN_W      = 16,
    parameter int CNT_W      = 32,
    parameter int ADDR_W     = 8,
    parameter int REG_W      = 32,
    parameter int RESET_LEN  = 4096,
    localparam int EMPTY_W   = $clog2(DATA_BYTES),
    localparam int BEAT_W    = DATA_BYTES*8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [NUM_PORTS-1:0]         st_valid,
    output logic [NUM_PORTS-1:0]         st_ready,
    input  logic [NUM_PORTS-1:0]         st_sop,
    input  logic [NUM_PORTS-1:0]         st_eop,
    input  logic [NUM_PORTS*EMPTY_W-1:0] st_empty,
    input  logic [NUM_PORTS*BEAT_W-1:0]  st_data,
    input  logic [ADDR_W-1:0]            reg_addr,
    input  logic                         reg_wr,
    input  logic [REG_W-1:0]             reg_wdata,
    input  logic                         reg_rd,
    output logic [REG_W-1:0]             reg_rdata,
    output logic                         reg_rvalid
);

    logic [LEN_W-1:0]           exp_len;
    logic [NUM_PORTS-1:0]       good_clr;
    logic [NUM_PORTS-1:0]       bad_clr;
    logic [NUM_PORTS*CNT_W-1:0] good_cnt;
    logic [NUM_PORTS*CNT_W-1:0] bad_cnt;
    pkt_verdict_t               verdict [NUM_PORTS];

    assign st_ready = '1;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        pkchk_lane #(
            .DATA_BYTES (DATA_BYTES),
            .LEN_W      (LEN_W)
        ) lane_i (
            .clk        (clk),
            .rst        (rst),
            .beat_valid (st_valid[p]),
            .beat_sop   (st_sop[p]),
            .beat_eop   (st_eop[p]),
            .beat_empty (st_empty[p*EMPTY_W +: EMPTY_W]),
            .beat_data  (st_data[p*BEAT_W +: BEAT_W]),
            .exp_len    (exp_len),
            .verdict    (verdict[p])
        );

        pkchk_sat_cnt #(.CNT_W(CNT_W)) good_i (
            .clk   (clk),
            .rst   (rst),
            .clr   (good_clr[p]),
            .add   (good_increment(verdict[p])),
            .count (good_cnt[p*CNT_W +: CNT_W])
        );

        pkchk_sat_cnt #(.CNT_W(CNT_W)) bad_i (
            .clk   (clk),
            .rst   (rst),
            .clr   (bad_clr[p]),
            .add   (bad_increment(verdict[p])),
            .count (bad_cnt[p*CNT_W +: CNT_W])
        );
    end

    pkchk_regs #(
        .NUM_PORTS (NUM_PORTS),
        .CNT_W     (CNT_W),
        .LEN_W     (LEN_W),
        .ADDR_W    (ADDR_W),
        .REG_W     (REG_W),
        .RESET_LEN (RESET_LEN)
    ) regs_i (
        .clk        (clk),
        .rst        (rst),
        .reg_addr   (reg_addr),
        .reg_wr     (reg_wr),
        .reg_wdata  (reg_wdata),
        .reg_rd     (reg_rd),
        .reg_rdata  (reg_rdata),
        .reg_rvalid (reg_rvalid),
        .good_cnt   (good_cnt),
        .bad_cnt    (bad_cnt),
        .exp_len    (exp_len),
        .good_clr   (good_clr),
        .bad_clr    (bad_clr)
    );

endmodule

// File: tb/stream_pkt_checker_tb_top.sv
module stream_pkt_checker_tb_top;

    localparam int NP  = 4;
    localparam int DB  = 64;
    localparam int EW  = 6;
    localparam int BW  = DB*8;
    localparam int CW  = 6;
    localparam int CMAX = (1 << CW) - 1;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [NP-1:0]     st_valid = '0;
    logic [NP-1:0]     st_ready;
    logic [NP-1:0]     st_sop = '0;
    logic [NP-1:0]     st_eop = '0;
    logic [NP*EW-1:0]  st_empty = '0;
    logic [NP*BW-1:0]  st_data = '0;
    logic [7:0]        reg_addr = '0;
    logic              reg_wr = 1'b0;
    logic [31:0]       reg_wdata = '0;
    logic              reg_rd = 1'b0;
    logic [31:0]       reg_rdata;
    logic              reg_rvalid;

    int checks = 0;
    int fails  = 0;
    int exp_good [NP];
    int exp_bad  [NP];
    int cur_len  = 4096;

    always #10 clk = ~clk;

    stream_pkt_checker #(.NUM_PORTS(NP), .DATA_BYTES(DB), .CNT_W(CW)) dut_i (
        .clk(clk), .rst(rst), .st_valid(st_valid), .st_ready(st_ready),
        .st_sop(st_sop), .st_eop(st_eop), .st_empty(st_empty), .st_data(st_data),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rd(reg_rd), .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid)
    );

    function automatic int sat(input int v);
        return (v > CMAX) ? CMAX : v;
    endfunction

    function automatic int good_ofs(input int p); return 'h10 + 8*p; endfunction
    function automatic int bad_ofs(input int p);  return 'h14 + 8*p; endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // All tasks start and end just after a falling edge.
    task automatic reg_write(input int a, input int d);
        reg_addr = 8'(a); reg_wdata = 32'(d); reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input int a, output int d);
        reg_addr = 8'(a); reg_rd = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0;
        check("R12 rvalid", int'(reg_rvalid), 1);
        d = int'(reg_rdata);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic beat(input int p, input logic [BW-1:0] d, input logic s,
                        input logic e, input int emp);
        st_valid[p] = 1'b1; st_sop[p] = s; st_eop[p] = e;
        st_empty[p*EW +: EW] = EW'(emp);
        st_data[p*BW +: BW] = d;
        @(negedge clk);
        st_valid[p] = 1'b0; st_sop[p] = 1'b0; st_eop[p] = 1'b0;
    endtask

    function automatic logic [BW-1:0] make_beat(input int b, input int nbytes,
                                                input int bad_at);
        logic [BW-1:0] d;
        for (int j = 0; j < DB; j++) begin
            int idx = b*DB + j;
            logic [7:0] v;
            v = (idx < nbytes) ? 8'(idx) : 8'($urandom);
            if (idx == bad_at) v = v ^ 8'h5A;
            d[8*j +: 8] = v;
        end
        return d;
    endfunction

    // Sends one packet; bad_at < 0 means no corrupted byte. Updates the model.
    task automatic send_pkt(input int p, input int nbytes, input int bad_at,
                            input bit with_sop);
        int nb = (nbytes + DB - 1) / DB;
        for (int b = 0; b < nb; b++) begin
            bit last = (b == nb - 1);
            int emp  = last ? (nb*DB - nbytes) : int'($urandom % DB);
            beat(p, make_beat(b, nbytes, bad_at), with_sop && (b == 0), last, emp);
        end
        if (with_sop && nbytes == cur_len && bad_at < 0) exp_good[p] = sat(exp_good[p] + 1);
        else                                              exp_bad[p]  = sat(exp_bad[p] + 1);
    endtask

    task automatic verify_port(input int p, input string req);
        int v;
        idle(2);
        reg_read(good_ofs(p), v); check({req, " good count"}, v, exp_good[p]);
        reg_read(bad_ofs(p), v);  check({req, " bad count"},  v, exp_bad[p]);
    endtask

    task automatic set_len(input int l);
        reg_write('h00, l);
        cur_len = l;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int v;
        int old;
        logic [BW-1:0] d;
        void'($urandom(32'h5EED_1234));
        for (int p = 0; p < NP; p++) begin exp_good[p] = 0; exp_bad[p] = 0; end
        idle(3);
        rst = 1'b0;
        @(negedge clk);

        // Reset state
        check("R1 ready after reset", int'(st_ready), 4'hF);
        reg_read('h00, v); check("R9 reset length", v, 4096);
        reg_read('h08, v); check("R9 unmapped offset", v, 0);
        for (int p = 0; p < NP; p++) verify_port(p, "R9 reset");

        // Full-size good packet at the reset length
        send_pkt(0, 4096, -1, 1);
        verify_port(0, "R2 good 4096");

        // Exact update edge of a counter
        set_len(100);
        reg_read('h00, v); check("R9 length readback", v, 100);
        old = exp_good[1];
        send_pkt(1, 100, -1, 1);
        reg_read(good_ofs(1), v); check("R12 one cycle after eop old", v, old);
        reg_read(good_ofs(1), v); check("R12 two cycles after eop new", v, old + 1);

        // Partial last beat with junk in invalid lanes, random empty on inner beats
        send_pkt(1, 100, -1, 1);
        send_pkt(1, 100, -1, 1);
        verify_port(1, "R3 empty handling");
        check("R1 ready during traffic", int'(st_ready), 4'hF);

        // Pattern errors: in a full lane, in the last valid lane
        send_pkt(2, 100, 70, 1);
        send_pkt(2, 100, 99, 1);
        verify_port(2, "R4 pattern");

        // Length errors
        send_pkt(2, 99, -1, 1);
        send_pkt(2, 101, -1, 1);
        send_pkt(2, 164, -1, 1);
        verify_port(2, "R5 length");

        // Start marker inside open packet
        beat(3, make_beat(0, 100, -1), 1'b1, 1'b0, 0);
        exp_bad[3]++;
        send_pkt(3, 100, -1, 1);
        verify_port(3, "R6 restart");

        // Data without a start marker
        beat(0, make_beat(0, 100, -1), 1'b0, 1'b1, 0);
        exp_bad[0]++;
        verify_port(0, "R7 orphan closed by eop");
        beat(0, make_beat(0, 100, -1), 1'b0, 1'b0, 0);
        beat(0, make_beat(1, 100, -1), 1'b0, 1'b0, 0);
        exp_bad[0]++;
        send_pkt(0, 100, -1, 1);
        verify_port(0, "R7 orphan closed by sop");
        send_pkt(0, 100, -1, 0);
        verify_port(0, "R7 orphan whole packet");

        // Same-cycle traffic on several ports
        set_len(64);
        d = make_beat(0, 64, -1);
        st_data = '0;
        st_data[0*BW +: BW] = d;
        st_data[1*BW +: BW] = make_beat(0, 64, 5);
        st_data[2*BW +: BW] = d;
        st_data[3*BW +: BW] = d;
        st_sop = 4'b0111; st_eop = 4'b0111; st_empty = '0; st_valid = 4'b0111;
        @(negedge clk);
        st_valid = '0; st_sop = '0; st_eop = '0;
        exp_good[0]++; exp_bad[1]++; exp_good[2]++;
        for (int p = 0; p < NP; p++) verify_port(p, "R8 independent ports");

        // Counter clear by write
        reg_write(good_ofs(0), 32'h1234);
        exp_good[0] = 0;
        verify_port(0, "R10 clear good");
        reg_write(bad_ofs(2), 0);
        exp_bad[2] = 0;
        verify_port(2, "R10 clear bad");
        verify_port(1, "R10 other port untouched");

        // Constrained random traffic
        set_len(130);
        for (int i = 0; i < 60; i++) begin
            int p = int'($urandom % NP);
            int n = ($urandom % 10 < 7) ? 130 : int'($urandom % 300) + 1;
            int bad_at = ($urandom % 5 == 0) ? int'($urandom % n) : -1;
            send_pkt(p, n, bad_at, 1);
        end
        for (int p = 0; p < NP; p++) verify_port(p, "R2 R4 R5 random");

        // Saturation
        set_len(64);
        reg_write(good_ofs(3), 0);
        exp_good[3] = 0;
        for (int i = 0; i < CMAX + 8; i++) send_pkt(3, 64, -1, 1);
        verify_port(3, "R11 saturation");
        check("R11 model at max", exp_good[3], CMAX);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule